// File: doc/BRIEF.md
# UV-Erasable Byte-Wide PROM Device Model

This block is a synthesizable, clock-sampled model of a byte-wide, ultraviolet-erasable programmable read-only memory. It serves as the target device in benches that exercise programmer logic. Every pin is reduced to a digital signal. Chip enable and output enable are active low. Three separate flags mark the high-voltage conditions: output enable at high voltage, address bit 9 at high voltage, and the programming supply raised. The data bus is split into an input byte and an output byte with an output-enable qualifier.

The pins are sampled on each rising clock edge. From them the model decodes these modes:

- read
- output disable
- standby
- identifier readout
- single-word program and verify
- eight-byte page latch load
- page program and page verify

Programming can only clear bits, so a stored byte becomes the AND of its old value and the new data. The array goes back to all ones only through the erase command. The array holds `2**ADDR_W` bytes; the full-size part has 19 address bits. The array is split into eight byte banks so that a whole page can be written in one cycle.

Top module: `eprom_model`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `dout_en_o` is 0 and `dout_o` is 8'h00.
- R2: Pins sampled at clock edge N appear on `dout_o`/`dout_en_o` after edge N+1. With `ce_n_i`=0, `oe_n_i`=0, `oe_hv_i`=0 and not an identifier access, the model drives the byte stored at `addr_i`.
- R3: When the model drives nothing, `dout_en_o` is 0 and `dout_o` is 8'h00. This holds whenever output enable is not low (`oe_n_i`=1 or `oe_hv_i`=1), and whenever `ce_n_i`=1 outside verify.
- R4: With `a9_hv_i`=1, `vpp_hi_i`=0 and chip and output enable low, the model drives 8'h07 when `addr_i[0]`=0 and 8'h20 when `addr_i[0]`=1. All other address bits are ignored.
- R5: One cycle of `erase_i` sets every stored byte to 8'hFF within `2**(ADDR_W-3)`+1 cycles.
- R6: Word program needs `vpp_hi_i`=1, no page mode, `oe_n_i`=1 and `oe_hv_i`=0. When `ce_n_i` is sampled 1 and then 0, the byte at `addr_i` becomes its old value AND `din_i`.
- R7: With `vpp_hi_i`=1, `ce_n_i`=1, `oe_n_i`=0 and `oe_hv_i`=0 (verify), the model drives the byte stored at `addr_i`.
- R8: Page mode is set when `vpp_hi_i` and `oe_hv_i` are sampled high together. It stays set while `vpp_hi_i` stays high, even after `oe_hv_i` falls. It is cleared when `vpp_hi_i` is sampled low, and a later program pulse then programs a single word.
- R9: With `vpp_hi_i`=1 and `oe_hv_i`=1, a falling chip enable stores `din_i` into latch byte `addr_i[2:0]`.
- R10: In page mode, with `oe_n_i`=1 and `oe_hv_i`=0, a falling chip enable programs the whole page `addr_i[ADDR_W-1:3]`. Byte i of that page becomes its old value AND latch byte i. The latch keeps its contents.
- R11: A high-voltage flag without its matching condition has no effect, and the model falls back to normal decoding. `oe_hv_i` with `vpp_hi_i`=0 sets no page mode and programs nothing. `a9_hv_i` with `vpp_hi_i`=1 returns the array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| erase_i | input | 1 | Erase command; starts the all-ones sweep |
| ce_n_i | input | 1 | Chip enable, active low; its falling edge is the program pulse |
| oe_n_i | input | 1 | Output enable, active low |
| oe_hv_i | input | 1 | Output enable pin held at high voltage |
| a9_hv_i | input | 1 | Address bit 9 held at high voltage (identifier request) |
| vpp_hi_i | input | 1 | Programming supply raised |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Byte presented by the programmer |
| dout_o | output | 8 | Byte driven by the device, 8'h00 when not driving |
| dout_en_o | output | 1 | High when the device drives the data bus |

## Verification
A reference model in the bench predicts both outputs on every cycle from the pins. Explicit checks sit at the cases listed below.

- Programming the same word twice with overlapping zero patterns shows AND behaviour rather than overwrite. Programming 8'hFF shows a no-op.
- Filling the latch and then programming two different pages from one latch load shows that the whole page is written and that the latch is kept.
- Dropping and raising the programming supply before a pulse shows that page mode is sticky and also that it is released, because only one byte of that page changes.
- Identifier reads at addresses differing only in the upper bits separate address bit 0 decoding from full decoding. Repeating them with the supply raised, or with output enable at high voltage but no supply, shows that the high-voltage flags are ignored out of context.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W     = 8;
  localparam int PAGE_BYTES = 8;
  localparam int PSEL_W     = $clog2(PAGE_BYTES);

  localparam logic [BYTE_W-1:0] MAKER_ID  = 8'h07;
  localparam logic [BYTE_W-1:0] DEVICE_ID = 8'h20;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_IDENT = 2'd2
  } out_src_e;
endpackage

// File: rtl/eprom_bank.sv
module eprom_bank #(
  parameter int ROW_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] cells [ROWS];

  // read-first single-clock dual-port array
  always_ff @(posedge clk) begin
    if (wr_en_i) cells[wr_row_i] <= wr_data_i;
    rd_data_o <= cells[rd_row_i];
  end
endmodule

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                erase_i,
  input  logic                                ce_n_i,
  input  logic                                oe_n_i,
  input  logic                                oe_hv_i,
  input  logic                                a9_hv_i,
  input  logic                                vpp_hi_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [BYTE_W-1:0]                   din_i,
  input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]   rd_bytes_i,
  output logic [PAGE_BYTES-1:0]               wr_en_o,
  output logic [ADDR_W-PSEL_W-1:0]            wr_row_o,
  output logic [PAGE_BYTES-1:0][BYTE_W-1:0]   wr_bytes_o,
  output out_src_e                            src_q_o,
  output logic [PSEL_W-1:0]                   bsel_q_o
);
  localparam int ROW_W = ADDR_W - PSEL_W;
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  logic                               ce_n_q;
  logic                               page_mode_q;
  logic                               sweep_q;
  logic [ROW_W-1:0]                   sweep_row_q;
  logic                               pend_q;
  logic [PAGE_BYTES-1:0]              pend_mask_q;
  logic [ROW_W-1:0]                   pend_row_q;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0]  pend_bytes_q;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0]  latch_q;

  logic       oe_low, strobe, latch_go, page_go, word_go;
  logic [PSEL_W-1:0] bsel;
  logic [ROW_W-1:0]  row;
  out_src_e   src_d;

  assign oe_low   = ~oe_n_i & ~oe_hv_i;
  assign strobe   = ce_n_q & ~ce_n_i & ~sweep_q;
  assign latch_go = strobe & vpp_hi_i & oe_hv_i;
  assign page_go  = strobe & vpp_hi_i &  page_mode_q & oe_n_i & ~oe_hv_i;
  assign word_go  = strobe & vpp_hi_i & ~page_mode_q & oe_n_i & ~oe_hv_i;
  assign bsel     = addr_i[PSEL_W-1:0];
  assign row      = addr_i[ADDR_W-1:PSEL_W];

  always_comb begin
    src_d = SRC_NONE;
    if (!ce_n_i && oe_low)
      src_d = (a9_hv_i && !vpp_hi_i) ? SRC_IDENT : SRC_ARRAY;
    else if (ce_n_i && oe_low && vpp_hi_i)
      src_d = SRC_ARRAY;
  end

  // write port: erase sweep wins over a pending program
  always_comb begin
    wr_en_o    = '0;
    wr_row_o   = pend_row_q;
    wr_bytes_o = rd_bytes_i & pend_bytes_q;
    if (sweep_q) begin
      wr_en_o    = '1;
      wr_row_o   = sweep_row_q;
      wr_bytes_o = '1;
    end else if (pend_q) begin
      wr_en_o    = pend_mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n_q       <= 1'b1;
      page_mode_q  <= 1'b0;
      sweep_q      <= 1'b0;
      sweep_row_q  <= '0;
      pend_q       <= 1'b0;
      pend_mask_q  <= '0;
      pend_row_q   <= '0;
      pend_bytes_q <= '1;
      latch_q      <= '1;
      src_q_o      <= SRC_NONE;
      bsel_q_o     <= '0;
    end else begin
      ce_n_q   <= ce_n_i;
      src_q_o  <= src_d;
      bsel_q_o <= bsel;

      if (!vpp_hi_i)    page_mode_q <= 1'b0;
      else if (oe_hv_i) page_mode_q <= 1'b1;

      if (latch_go) latch_q[bsel] <= din_i;

      pend_q     <= page_go | word_go;
      pend_row_q <= row;
      if (page_go) begin
        pend_mask_q  <= '1;
        pend_bytes_q <= latch_q;
      end else begin
        pend_mask_q  <= PAGE_BYTES'(1) << bsel;
        pend_bytes_q <= {PAGE_BYTES{din_i}};
      end

      if (sweep_q) begin
        sweep_row_q <= sweep_row_q + 1'b1;
        if (sweep_row_q == LAST_ROW) sweep_q <= 1'b0;
      end else if (erase_i) begin
        sweep_q     <= 1'b1;
        sweep_row_q <= '0;
      end
    end
  end

  p_pmode_set_r8: assert property (@(posedge clk) disable iff (rst)
    (vpp_hi_i && oe_hv_i) |=> page_mode_q)
    else $error("page mode not entered");

  p_pmode_clr_r8: assert property (@(posedge clk) disable iff (rst)
    !vpp_hi_i |=> !page_mode_q)
    else $error("page mode survived supply drop");

  p_latch_kept_r10: assert property (@(posedge clk) disable iff (rst)
    page_go |=> $stable(latch_q))
    else $error("latch changed by page program");

  p_word_one_byte_r6: assert property (@(posedge clk) disable iff (rst)
    word_go |=> (pend_q && $onehot(pend_mask_q)))
    else $error("word program touches more than one byte");

  p_hv_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (oe_hv_i && !vpp_hi_i) |=> !pend_q)
    else $error("program without supply");
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              oe_hv_i,
  input  logic              a9_hv_i,
  input  logic              vpp_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        din_i,
  output logic [7:0]        dout_o,
  output logic              dout_en_o
);
  localparam int ROW_W = ADDR_W - PSEL_W;

  logic [PAGE_BYTES-1:0][BYTE_W-1:0] rd_bytes;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] wr_bytes;
  logic [PAGE_BYTES-1:0]             wr_en;
  logic [ROW_W-1:0]                  wr_row;
  out_src_e                          src_q;
  logic [PSEL_W-1:0]                 bsel_q;

  eprom_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .erase_i    (erase_i),
    .ce_n_i     (ce_n_i),
    .oe_n_i     (oe_n_i),
    .oe_hv_i    (oe_hv_i),
    .a9_hv_i    (a9_hv_i),
    .vpp_hi_i   (vpp_hi_i),
    .addr_i     (addr_i),
    .din_i      (din_i),
    .rd_bytes_i (rd_bytes),
    .wr_en_o    (wr_en),
    .wr_row_o   (wr_row),
    .wr_bytes_o (wr_bytes),
    .src_q_o    (src_q),
    .bsel_q_o   (bsel_q)
  );

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_bank
    eprom_bank #(.ROW_W(ROW_W), .DATA_W(BYTE_W)) i_bank (
      .clk       (clk),
      .rd_row_i  (addr_i[ADDR_W-1:PSEL_W]),
      .rd_data_o (rd_bytes[g]),
      .wr_en_i   (wr_en[g]),
      .wr_row_i  (wr_row),
      .wr_data_i (wr_bytes[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o    <= '0;
      dout_en_o <= 1'b0;
    end else begin
      unique case (src_q)
        SRC_ARRAY: begin
          dout_o    <= rd_bytes[bsel_q];
          dout_en_o <= 1'b1;
        end
        SRC_IDENT: begin
          dout_o    <= bsel_q[0] ? DEVICE_ID : MAKER_ID;
          dout_en_o <= 1'b1;
        end
        default: begin
          dout_o    <= '0;
          dout_en_o <= 1'b0;
        end
      endcase
    end
  end

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !dout_en_o |-> (dout_o == 8'h00))
    else $error("bus value while not driving");

  p_ident_maker_r4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_i && !oe_n_i && !oe_hv_i && a9_hv_i && !vpp_hi_i && !addr_i[0])
      |-> ##2 (dout_en_o && dout_o == 8'h07))
    else $error("maker code wrong");

  p_ident_device_r4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_i && !oe_n_i && !oe_hv_i && a9_hv_i && !vpp_hi_i && addr_i[0])
      |-> ##2 (dout_en_o && dout_o == 8'h20))
    else $error("device code wrong");
endmodule

// File: tb/test_eprom_model.sv
module test_eprom_model;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGES  = DEPTH / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic erase = 1'b0, ce_n = 1'b1, oe_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0, vpp = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en;

  always #5 clk = ~clk;

  eprom_model #(.ADDR_W(ADDR_W)) i_eprom_model (
    .clk(clk), .rst(rst), .erase_i(erase), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .oe_hv_i(oe_hv), .a9_hv_i(a9_hv), .vpp_hi_i(vpp), .addr_i(addr),
    .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  int n_chk = 0, n_bad = 0;
  bit armed = 0;

  // behavioural reference
  logic [7:0] rmem [DEPTH];
  logic [7:0] rlatch [8];
  bit r_pm = 0, r_prevce = 1;
  int r_sweep = 0;
  logic nxt_en = 0, show_en = 0;
  logic [7:0] nxt_val = 0, show_val = 0;
  string nxt_tag = "R1", show_tag = "R1";

  initial begin
    for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) rlatch[i] = 8'hFF;
  end

  always @(posedge clk) begin
    show_en = nxt_en; show_val = nxt_val; show_tag = nxt_tag;
    if (rst) begin
      nxt_en = 0; nxt_val = 0; nxt_tag = "R1";
      r_pm = 0; r_prevce = 1; r_sweep = 0;
    end else begin
      bit oelow, strobe;
      oelow = !oe_n && !oe_hv;
      if (!ce_n && oelow && a9_hv && !vpp) begin
        nxt_en = 1; nxt_val = addr[0] ? 8'h20 : 8'h07; nxt_tag = "R4";
      end else if (!ce_n && oelow) begin
        nxt_en = 1; nxt_val = rmem[addr]; nxt_tag = "R2";
      end else if (ce_n && oelow && vpp) begin
        nxt_en = 1; nxt_val = rmem[addr]; nxt_tag = "R7";
      end else begin
        nxt_en = 0; nxt_val = 0; nxt_tag = "R3";
      end
      strobe = r_prevce && !ce_n && (r_sweep == 0);
      if (strobe && vpp && oe_hv)
        rlatch[addr[2:0]] = din;
      else if (strobe && vpp && r_pm && oe_n)
        for (int i = 0; i < 8; i++) rmem[{addr[ADDR_W-1:3], 3'(i)}] &= rlatch[i];
      else if (strobe && vpp && !r_pm && oe_n)
        rmem[addr] &= din;
      if (!vpp) r_pm = 0; else if (oe_hv) r_pm = 1;
      if (r_sweep > 0) r_sweep--;
      else if (erase) begin
        for (int i = 0; i < DEPTH; i++) rmem[i] = 8'hFF;
        r_sweep = PAGES;
      end
      r_prevce = ce_n;
    end
  end

  always @(negedge clk) if (armed) begin
    n_chk++;
    if (dout_en !== show_en || dout !== show_val) begin
      n_bad++;
      $display("FAIL %s cycle compare: got en=%0b data=%02h, expected en=%0b data=%02h",
               show_tag, dout_en, dout, show_en, show_val);
    end
  end

  task automatic chk(string tag, logic en, logic [7:0] val);
    n_chk++;
    if (dout_en !== en || dout !== val) begin
      n_bad++;
      $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
               tag, dout_en, dout, en, val);
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; oe_hv = 0; a9_hv = 0; erase = 0;
  endtask

  task automatic read_at(logic [ADDR_W-1:0] a, string tag, logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    step(3); chk(tag, 1, v);
    ce_n = 1; oe_n = 1; step(1);
  endtask

  task automatic verify_at(logic [ADDR_W-1:0] a, string tag, logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1; oe_n = 0;
    step(3); chk(tag, 1, v);
    oe_n = 1; step(1);
  endtask

  task automatic ce_pulse(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d;
    step(1); ce_n = 0;
    step(2); ce_n = 1;
    step(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    idle();
    step(4); armed = 1; step(1);
    chk("R1", 0, 8'h00);
    @(negedge clk); rst = 0; step(1);
    chk("R1", 0, 8'h00);

    // R5 erase
    @(negedge clk); erase = 1; step(1); erase = 0;
    step(PAGES + 4);
    read_at(10'h000, "R5", 8'hFF);
    read_at(10'h3FF, "R5", 8'hFF);
    read_at(10'h005, "R5", 8'hFF);

    // R6 / R7 word program and verify
    @(negedge clk); vpp = 1; step(2);
    ce_pulse(10'h005, 8'h5A);
    verify_at(10'h005, "R7", 8'h5A);
    ce_pulse(10'h005, 8'h0F);
    verify_at(10'h005, "R6", 8'h0A);
    ce_pulse(10'h005, 8'hFF);
    verify_at(10'h005, "R6", 8'h0A);
    verify_at(10'h004, "R6", 8'hFF);
    @(negedge clk); vpp = 0; step(2);
    read_at(10'h005, "R2", 8'h0A);

    // R3 standby and output disable
    @(negedge clk); addr = 10'h005; ce_n = 1; oe_n = 0; step(3);
    chk("R3", 0, 8'h00);
    @(negedge clk); ce_n = 0; oe_n = 1; step(3);
    chk("R3", 0, 8'h00);
    idle(); step(1);

    // R4 identifier
    @(negedge clk); a9_hv = 1; step(1);
    read_at(10'h000, "R4", 8'h07);
    read_at(10'h3FE, "R4", 8'h07);
    read_at(10'h001, "R4", 8'h20);
    read_at(10'h2A5, "R4", 8'h20);
    // R11 identifier ignored with supply raised
    @(negedge clk); vpp = 1; step(1);
    read_at(10'h005, "R11", 8'h0A);
    idle(); vpp = 0; step(2);

    // R11 high-voltage OE without supply
    @(negedge clk); oe_hv = 1; oe_n = 1; ce_n = 0; step(3);
    chk("R11", 0, 8'h00);
    ce_n = 1; step(1);
    ce_pulse(10'h005, 8'h00);
    idle(); step(1);
    read_at(10'h005, "R11", 8'h0A);

    // R9 latch load, R8 sticky mode, R10 page program
    @(negedge clk); vpp = 1; step(2);
    @(negedge clk); oe_hv = 1; step(1);
    for (int i = 0; i < 8; i++) ce_pulse(10'(10'h080 + i), 8'(8'hC3 ^ (8'h11 * i)));
    @(negedge clk); oe_hv = 0; step(2);
    for (int i = 0; i < 8; i++) verify_at(10'(10'h080 + i), "R9", 8'hFF);
    ce_pulse(10'h080, 8'h00);
    for (int i = 0; i < 8; i++) verify_at(10'(10'h080 + i), "R10", 8'(8'hC3 ^ (8'h11 * i)));
    ce_pulse(10'h103, 8'h00);
    for (int i = 0; i < 8; i++) verify_at(10'(10'h100 + i), "R10", 8'(8'hC3 ^ (8'h11 * i)));
    verify_at(10'h0FF, "R10", 8'hFF);

    // R8 mode released by supply drop
    @(negedge clk); vpp = 0; step(2);
    @(negedge clk); vpp = 1; step(2);
    ce_pulse(10'h200, 8'h3C);
    verify_at(10'h200, "R8", 8'h3C);
    verify_at(10'h201, "R8", 8'hFF);
    verify_at(10'h207, "R8", 8'hFF);

    idle(); vpp = 0; step(3);
    finish_run();
  end
endmodule